// File: doc/BRIEF.md
# Multidrop Test-Bus Slot Address Decoder

This block sits behind the backplane boundary-scan TAP controller of a bridge that shares one test bus with many other boards. During an address phase the test master shifts a 7-bit address into the instruction register. When the TAP reaches Update-IR, the block classifies that address and compares it with the board's static slot pins. It then records whether the bridge is now selected, part of a broadcast, part of a multicast group, or answering an interrogation.

The address space has five classes. Address zero is reserved. A range of unique board addresses follows it. Above that range come a handful of multicast group codes, then one interrogation code, then the all-ones broadcast code. The flags hold their value between address phases and are cleared asynchronously by the test reset. A separate return-line enable is raised only for a unique selection, so that a broadcast or multicast never lets several boards drive the shared TDO line at once.

Top module: `slot_addr_decoder`

## Requirements
- R1: While `trst_n` is low, all five outputs are 0, asynchronously and regardless of the clock.
- R2: An update with an address in 0x01..0x79 equal to `slot_id` sets `selected` and `tdo_en`, and clears the other three flags.
- R3: An update with an address in 0x01..0x79 that differs from `slot_id` clears all five outputs.
- R4: An update with address 0x00 clears all five outputs, even when `slot_id` is 0x00.
- R5: An update with address 0x7A+g (g = 0..3) sets `selected` and `group_active` when `group_member[g]` is 1; otherwise it clears all outputs. `tdo_en` stays 0 in both cases.
- R6: An update with address 0x7E sets `interrogate_active` and leaves `selected`, `bcast_active`, `group_active` and `tdo_en` at 0.
- R7: An update with address 0x7F sets `selected` and `bcast_active` for every slot value, with `tdo_en` at 0.
- R8: `tdo_en` is never 1 while `bcast_active` or `group_active` is 1.
- R9: The outputs change only at a rising `tck` edge where `addr_update` is 1, and take effect from that edge. On other edges they hold, whatever `ir_addr` does.
- R10: A `slot_id` of 0x00 or of 0x7A..0x7F never produces a unique match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| slot_id | input | 7 | Static slot address pins of this board |
| ir_addr | input | 7 | Address captured in the instruction register |
| addr_update | input | 1 | Update-IR strobe of the address phase |
| group_member | input | 4 | Membership bit per multicast group, bit g for group g |
| selected | output | 1 | Bridge is selected (unique, group or broadcast) |
| bcast_active | output | 1 | Broadcast address accepted |
| group_active | output | 1 | A multicast group this board belongs to was addressed |
| interrogate_active | output | 1 | Interrogation address accepted |
| tdo_en | output | 1 | This board may drive the shared return line |

## Verification
Every flag is a register that loads on the update strobe, so a wrong class boundary, a wrong group index or a wrong slot compare appears on the outputs one edge after the strobe that set it up. It stays there until the next strobe. The bench sweeps every address against every slot value, with membership patterns that vary with the slot, so each boundary between classes is hit from both sides. A missing hold or a lost reset shows up on the first idle edge or at the instant `trst_n` falls.

// File: rtl/sad_pkg.sv
package sad_pkg;

    typedef enum logic [2:0] {
        CLS_RESERVED,
        CLS_UNIQUE,
        CLS_GROUP,
        CLS_INTERROGATE,
        CLS_BCAST
    } addr_class_e;

    typedef struct packed {
        logic sel;
        logic bcast;
        logic grp;
        logic intg;
        logic tdo;
    } sel_state_t;

endpackage

// File: rtl/sad_classifier.sv
module sad_classifier #(
    parameter int ADDR_W     = 7,
    parameter int NUM_GROUPS = 4,
    parameter int GIDX_W     = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output sad_pkg::addr_class_e cls,
    output logic [GIDX_W-1:0]   grp_idx
);
    localparam logic [ADDR_W-1:0] BCAST_A     = '1;
    localparam logic [ADDR_W-1:0] INTG_A      = BCAST_A - 1'b1;
    localparam logic [ADDR_W-1:0] GROUP_BASE  = INTG_A - ADDR_W'(NUM_GROUPS);
    localparam logic [ADDR_W-1:0] LAST_UNIQUE = GROUP_BASE - 1'b1;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset  = addr - GROUP_BASE;
        grp_idx = offset[GIDX_W-1:0];
        if (addr == '0)
            cls = sad_pkg::CLS_RESERVED;
        else if (addr <= LAST_UNIQUE)
            cls = sad_pkg::CLS_UNIQUE;
        else if (addr < INTG_A)
            cls = sad_pkg::CLS_GROUP;
        else if (addr == INTG_A)
            cls = sad_pkg::CLS_INTERROGATE;
        else
            cls = sad_pkg::CLS_BCAST;
    end
endmodule

// File: rtl/sad_group_gate.sv
module sad_group_gate #(
    parameter int NUM_GROUPS = 4,
    parameter int GIDX_W     = 2
) (
    input  logic                  grp_addr,
    input  logic [GIDX_W-1:0]     grp_idx,
    input  logic [NUM_GROUPS-1:0] member,
    output logic                  accept
);
    logic [NUM_GROUPS-1:0] hit;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
        assign hit[g] = grp_addr && (grp_idx == GIDX_W'(g)) && member[g];
    end

    assign accept = |hit;
endmodule

// File: rtl/slot_addr_decoder.sv
module slot_addr_decoder #(
    parameter int ADDR_W     = 7,
    parameter int NUM_GROUPS = 4
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic [ADDR_W-1:0]     slot_id,
    input  logic [ADDR_W-1:0]     ir_addr,
    input  logic                  addr_update,
    input  logic [NUM_GROUPS-1:0] group_member,
    output logic                  selected,
    output logic                  bcast_active,
    output logic                  group_active,
    output logic                  interrogate_active,
    output logic                  tdo_en
);
    localparam int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    sad_pkg::addr_class_e cls;
    logic [GIDX_W-1:0]    grp_idx;
    logic                 grp_ok;
    sad_pkg::sel_state_t  state_d, state_q;

    sad_classifier #(
        .ADDR_W    (ADDR_W),
        .NUM_GROUPS(NUM_GROUPS),
        .GIDX_W    (GIDX_W)
    ) u_cls (
        .addr   (ir_addr),
        .cls    (cls),
        .grp_idx(grp_idx)
    );

    sad_group_gate #(
        .NUM_GROUPS(NUM_GROUPS),
        .GIDX_W    (GIDX_W)
    ) u_grp (
        .grp_addr(cls == sad_pkg::CLS_GROUP),
        .grp_idx (grp_idx),
        .member  (group_member),
        .accept  (grp_ok)
    );

    always_comb begin
        state_d = state_q;
        if (addr_update) begin
            state_d = '0;
            unique case (cls)
                sad_pkg::CLS_UNIQUE: begin
                    if (ir_addr == slot_id) begin
                        state_d.sel = 1'b1;
                        state_d.tdo = 1'b1;
                    end
                end
                sad_pkg::CLS_GROUP: begin
                    if (grp_ok) begin
                        state_d.sel = 1'b1;
                        state_d.grp = 1'b1;
                    end
                end
                sad_pkg::CLS_INTERROGATE: state_d.intg = 1'b1;
                sad_pkg::CLS_BCAST: begin
                    state_d.sel   = 1'b1;
                    state_d.bcast = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= '0;
        else         state_q <= state_d;
    end

    assign selected           = state_q.sel;
    assign bcast_active       = state_q.bcast;
    assign group_active       = state_q.grp;
    assign interrogate_active = state_q.intg;
    assign tdo_en             = state_q.tdo;
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
    parameter int ADDR_W     = 7,
    parameter int NUM_GROUPS = 4
) (
    input logic                  tck,
    input logic                  trst_n,
    input logic [ADDR_W-1:0]     slot_id,
    input logic [ADDR_W-1:0]     ir_addr,
    input logic                  addr_update,
    input logic [NUM_GROUPS-1:0] group_member,
    input logic                  selected,
    input logic                  bcast_active,
    input logic                  group_active,
    input logic                  interrogate_active,
    input logic                  tdo_en
);
    localparam logic [ADDR_W-1:0] BCAST_A     = '1;
    localparam logic [ADDR_W-1:0] INTG_A      = BCAST_A - 1'b1;
    localparam logic [ADDR_W-1:0] GROUP_BASE  = INTG_A - ADDR_W'(NUM_GROUPS);
    localparam logic [ADDR_W-1:0] LAST_UNIQUE = GROUP_BASE - 1'b1;

    AST_RESET_CLEAR: assert property (@(posedge tck)
        !trst_n |-> !(selected || bcast_active || group_active || interrogate_active || tdo_en)); // R1

    AST_UNIQUE_MATCH: assert property (@(posedge tck) disable iff (!trst_n)
        addr_update && ir_addr != '0 && ir_addr <= LAST_UNIQUE && ir_addr == slot_id
        |=> selected && tdo_en && !bcast_active && !group_active); // R2

    AST_RESERVED_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
        addr_update && ir_addr == '0 |=> !selected && !tdo_en); // R4

    AST_GROUP_NONMEMBER: assert property (@(posedge tck) disable iff (!trst_n)
        addr_update && ir_addr >= GROUP_BASE && ir_addr < INTG_A && group_member == '0
        |=> !selected && !group_active); // R5

    AST_INTG_NO_SEL: assert property (@(posedge tck) disable iff (!trst_n)
        interrogate_active |-> !selected && !tdo_en); // R6

    AST_BCAST_ALL: assert property (@(posedge tck) disable iff (!trst_n)
        addr_update && ir_addr == BCAST_A |=> selected && bcast_active); // R7

    AST_TDO_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
        (bcast_active || group_active) |-> !tdo_en); // R8

    AST_HOLD_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
        !addr_update |=> $stable({selected, bcast_active, group_active, interrogate_active, tdo_en})); // R9

    AST_ONE_CLASS: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bcast_active, group_active, interrogate_active, tdo_en})); // R8
endmodule

bind slot_addr_decoder sad_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_GROUPS(NUM_GROUPS)
) u_chk (.*);

// File: tb/sim_slot_addr_decoder.sv
module sim_slot_addr_decoder;
    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic [6:0] slot_id = '0;
    logic [6:0] ir_addr = '0;
    logic       addr_update = 1'b0;
    logic [3:0] group_member = '0;
    logic selected, bcast_active, group_active, interrogate_active, tdo_en;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 tck = ~tck;

    slot_addr_decoder u0 (
        .tck(tck), .trst_n(trst_n), .slot_id(slot_id), .ir_addr(ir_addr),
        .addr_update(addr_update), .group_member(group_member),
        .selected(selected), .bcast_active(bcast_active), .group_active(group_active),
        .interrogate_active(interrogate_active), .tdo_en(tdo_en)
    );

    function automatic logic [4:0] outs();
        return {selected, bcast_active, group_active, interrogate_active, tdo_en};
    endfunction

    // expected {sel, bcast, grp, intg, tdo}
    function automatic logic [4:0] expect_flags(int a, int s, logic [3:0] m);
        if (a == 0)       return 5'b00000;
        if (a <= 'h79)    return (a == s) ? 5'b10001 : 5'b00000;
        if (a <= 'h7D)    return m[a - 'h7A] ? 5'b10100 : 5'b00000;
        if (a == 'h7E)    return 5'b00010;
        return 5'b11000;
    endfunction

    function automatic string req_of(int a, int s);
        if (a == 0)    return "R4";
        if (a <= 'h79) begin
            if (a == s) return "R2";
            if (s == 0 || s > 'h79) return "R10";
            return "R3";
        end
        if (a <= 'h7D) return "R5";
        if (a == 'h7E) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (slot=%h addr=%h member=%b)",
                     req, act, exp, slot_id, ir_addr, group_member);
        end
    endtask

    task automatic strobe(int a);
        @(negedge tck);
        ir_addr     = 7'(a);
        addr_update = 1'b1;
        @(negedge tck);
        addr_update = 1'b0;
    endtask

    initial begin
        // R1: reset state
        #5;
        check("R1", outs(), 5'b00000);
        @(negedge tck);
        @(negedge tck);
        trst_n = 1'b1;

        for (int s = 0; s < 128; s++) begin
            slot_id      = 7'(s);
            group_member = 4'(s * 5 + (s >> 4));
            for (int a = 0; a < 128; a++) begin
                logic [4:0] e;
                e = expect_flags(a, s, group_member);
                strobe(a);
                check(req_of(a, s), outs(), e);
                n_tests++;
                if (tdo_en && (bcast_active || group_active)) begin
                    n_fail++;
                    $display("FAIL R8 actual tdo=%b bcast=%b grp=%b expected tdo=0",
                             tdo_en, bcast_active, group_active);
                end
                // R9: idle edge with a different address must not change anything
                ir_addr = 7'(a ^ 7'h55);
                @(negedge tck);
                check("R9", outs(), e);
            end
        end

        // R1: asynchronous clear from a selected state, away from any edge
        slot_id = 7'h23;
        strobe('h23);
        check("R2", outs(), 5'b10001);
        #3 trst_n = 1'b0;
        #1 check("R1", outs(), 5'b00000);
        @(negedge tck);
        check("R1", outs(), 5'b00000);
        trst_n = 1'b1;
        strobe('h7F);
        check("R7", outs(), 5'b11000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule